// File: doc/BRIEF.md
# Transmit FIFO with Watermark Request

This block is a sixteen-entry transmit queue placed between a processor or DMA write side and a serial shifter that drains it. Words enter through a push port and leave through a pop port in arrival order. The oldest word is always shown on the pop data output. The block tracks how many entries are still free and reports that count through a read-only field of a 16-bit control register.

A 3-bit threshold code in the same register sets how many empty entries are needed before the block asks for more data. The request output is registered. It can be asserted only while a separate request-enable input is high. Only five codes are legal. A write of any other code is stored as the all-empty code, and a sticky flag records the illegal write. The storage depth stays at sixteen whichever code is chosen. Code 111 is meant for processor-driven refill only, because it requests data as soon as a single entry is free.

Top module: `tx_watermark_fifo`

## Requirements
- R1: After reset, reg_rdata reads 16'h1000: threshold code 000 in bits 15:13, free count 16 in bits 12:8, and zero in bits 7:0. xfer_req, ovf_flag, udf_flag and cfg_err are all 0.
- R2: reg_rdata bits 12:8 always equal 16 minus the number of stored words. The value runs from 0 when the FIFO is full to 16 when it is empty.
- R3: Words are popped in the order they were pushed. pop_data shows the oldest stored word whenever the FIFO holds at least one word.
- R4: A push while 16 words are stored is dropped and the contents do not change. ovf_flag goes to 1 on the next clock and stays 1 until reset.
- R5: A pop while the FIFO is empty is ignored. udf_flag goes to 1 on the next clock and stays 1 until reset. A push and a pop in the same cycle are judged against the count held before that cycle.
- R6: Each threshold code sets the minimum free count needed for a request: 000 needs 16, 100 needs 12, 101 needs 8, 110 needs 4, and 111 needs 1.
- R7: A register write with bits 15:13 equal to 001, 010 or 011 stores code 000, and bits 15:13 then read 000. cfg_err goes to 1 on the next clock and stays 1 until reset.
- R8: xfer_req is registered. After each clock it equals the following: req_en in the previous cycle was 1, and the free count after that cycle's push and pop is at least the threshold of the code in force after that cycle's write.
- R9: A register write changes only the threshold code. Bits 12:0 of reg_wdata have no effect.
- R10: The FIFO holds 16 words under every threshold code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read value |
| req_en | input | 1 | Enable for the transfer request |
| push | input | 1 | Push strobe |
| push_data | input | DW | Word to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | DW | Oldest stored word |
| xfer_req | output | 1 | Registered transfer request |
| ovf_flag | output | 1 | Sticky flag for a push while full |
| udf_flag | output | 1 | Sticky flag for a pop while empty |
| cfg_err | output | 1 | Sticky flag for an illegal threshold write |

## Verification
The assertions expect every control input to be a known 0 or 1 at each rising edge. They also expect the request, the flags and the free count to be sampled only after reset has been released. The bench meets this by driving all inputs at the falling edge from a single process, and it holds them at 0 during reset. Random register writes draw all eight codes, prohibited ones included, and random push and pop strobes are biased so the FIFO often reaches both full and empty. Stray pushes and pops at those limits therefore exercise the overflow and underflow paths, and no input falls outside its defined range.

// File: rtl/tx_watermark_fifo.sv
module tx_watermark_fifo #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          req_en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          xfer_req,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          cfg_err
);
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx, free, free_nx;
  logic [2:0]    code, code_nx, wr_code;
  logic          do_push, do_pop, bad_wr;

  function automatic logic [CW-1:0] need(input logic [2:0] c);
    case (c)
      3'b100:  need = CW'(12);
      3'b101:  need = CW'(8);
      3'b110:  need = CW'(4);
      3'b111:  need = CW'(1);
      default: need = FULL;
    endcase
  endfunction

  assign do_push = push && (cnt != FULL);
  assign do_pop  = pop && (cnt != '0);
  assign cnt_nx  = cnt + CW'(do_push) - CW'(do_pop);
  assign free    = FULL - cnt;
  assign free_nx = FULL - cnt_nx;
  assign wr_code = reg_wdata[15:13];
  assign bad_wr  = reg_we && !wr_code[2] && (wr_code != 3'b000);
  assign code_nx = !reg_we ? code : (bad_wr ? 3'b000 : wr_code);

  assign reg_rdata = {code, free, 8'h00};
  assign pop_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      code     <= 3'b000;
      xfer_req <= 1'b0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt      <= cnt_nx;
      code     <= code_nx;
      xfer_req <= req_en && (free_nx >= need(code_nx));
      if (push && !do_push) ovf_flag <= 1'b1;
      if (pop && !do_pop)   udf_flag <= 1'b1;
      if (bad_wr)           cfg_err  <= 1'b1;
    end
  end

  // R2
  free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[12:8] <= FULL);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && reg_rdata[12:8] == '0) |=> (ovf_flag && reg_rdata[12:8] == '0));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && reg_rdata[12:8] == FULL) |=> (udf_flag && reg_rdata[12:8] == FULL));

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:13] == 3'b000) || reg_rdata[15]);

  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> !xfer_req);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
endmodule

// File: tb/tx_watermark_fifo_bench.sv
module tx_watermark_fifo_bench;
  localparam int CLK_NS = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, req_en = 0, push = 0, pop = 0;
  logic [15:0] reg_wdata = '0;
  logic [DW-1:0] push_data = '0;
  logic [15:0] reg_rdata;
  logic [DW-1:0] pop_data;
  logic xfer_req, ovf_flag, udf_flag, cfg_err;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] m_mem [16];
  int m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [2:0] m_code = 0;
  logic m_req = 0, m_ovf = 0, m_udf = 0, m_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  tx_watermark_fifo #(.DW(DW)) u_tx_watermark_fifo (
    .clk, .rst_n, .reg_we, .reg_wdata, .reg_rdata, .req_en,
    .push, .push_data, .pop, .pop_data, .xfer_req,
    .ovf_flag, .udf_flag, .cfg_err);

  function automatic int need_of(input logic [2:0] c);
    case (c)
      3'b100: return 12;
      3'b101: return 8;
      3'b110: return 4;
      3'b111: return 1;
      default: return 16;
    endcase
  endfunction

  function automatic logic [15:0] exp_reg();
    return {m_code, 5'(16 - m_cnt), 8'h00};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R2 reg_rdata"}, reg_rdata, exp_reg());
    cmp({tag, " R8 xfer_req"}, xfer_req, m_req);
    cmp({tag, " R4 ovf_flag"}, ovf_flag, m_ovf);
    cmp({tag, " R5 udf_flag"}, udf_flag, m_udf);
    cmp({tag, " R7 cfg_err"}, cfg_err, m_err);
  endtask

  task automatic step(input string tag, input logic we, input logic [15:0] wd,
                      input logic en, input logic pu, input logic [DW-1:0] pd, input logic po);
    bit dpu, dpo;
    reg_we = we; reg_wdata = wd; req_en = en; push = pu; push_data = pd; pop = po;
    #1;
    if (m_cnt > 0) cmp({tag, " R3 pop_data"}, pop_data, m_mem[m_rp]);
    dpu = pu && m_cnt < 16;
    dpo = po && m_cnt > 0;
    if (pu && !dpu) m_ovf = 1;
    if (po && !dpo) m_udf = 1;
    if (dpu) begin m_mem[m_wp] = pd; m_wp = (m_wp + 1) % 16; end
    if (dpo) m_rp = (m_rp + 1) % 16;
    m_cnt = m_cnt + int'(dpu) - int'(dpo);
    if (we) begin
      if (wd[15:13] inside {3'b001, 3'b010, 3'b011}) begin m_code = 0; m_err = 1; end
      else m_code = wd[15:13];
    end
    m_req = en && ((16 - m_cnt) >= need_of(m_code));
    @(negedge clk);
    reg_we = 0; push = 0; pop = 0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 reg_rdata", reg_rdata, 16'h1000);
    cmp("R1 xfer_req", xfer_req, 0);
    cmp("R1 flags", {ovf_flag, udf_flag, cfg_err}, 0);

    // R8 gating and empty-threshold request under code 000
    step("R8 en off", 0, 0, 0, 0, 0, 0);
    step("R8 en on", 0, 0, 1, 0, 0, 0);
    step("R6 code000 one push", 0, 0, 1, 1, 8'h11, 0);

    // R5 pop on empty (after draining)
    step("R3 drain", 0, 0, 1, 0, 0, 1);
    step("R5 pop empty", 0, 0, 1, 0, 0, 1);

    // R9 other bits ignored; R6 code 110 threshold 4
    step("R9 write", 1, 16'hDFFF, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step("R6 fill 110", 0, 0, 1, 1, 8'(i + 8'h40), 0);
    step("R6 free4", 0, 0, 1, 1, 8'h4C, 0);
    // R10 fill to 16 under code 111, then R4 overflow
    step("R10 code111", 1, 16'hE000, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R10 fill", 0, 0, 1, 1, 8'(i + 8'h50), 0);
    cmp("R10 full", reg_rdata[12:8], 0);
    step("R4 push full", 0, 0, 1, 1, 8'hEE, 0);
    step("R4 push pop full", 0, 0, 1, 1, 8'hEF, 1);
    // R7 prohibited codes
    step("R7 code010", 1, 16'h4000, 1, 0, 0, 0);
    step("R7 code101", 1, 16'hA000, 1, 0, 0, 0);
    step("R7 code011", 1, 16'h6000, 1, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic we;
      we = ($urandom % 16) == 0;
      step("rand", we, 16'($urandom), ($urandom % 8) != 0,
           ($urandom % 100) < ((n / 500) % 2 ? 70 : 35), 8'($urandom),
           ($urandom % 100) < ((n / 500) % 2 ? 35 : 70));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule